// File: doc/BRIEF.md
# RNS Quotient-First Scaling Unit

This block divides a residue-coded integer by a divisor fixed in advance and returns an estimate of the quotient, also in residue form. It never converts the number out of residue form and never extends the base. An upstream stage supplies the per-channel reconstruction values (one value per base modulus), the reconstruction coefficient and a small correction count. This block uses those values to index two precomputed tables. The first table holds, for each channel and each reconstruction value, an integer quotient part with its residues and a truncated binary fraction. The second table holds, for each coefficient value, an integer part with its residues and a fraction rounded upward.

The block walks the table terms one per clock. In every residue channel, and in one extra redundant channel, it adds the per-channel integer residues and subtracts the coefficient residue. In parallel it adds the fractions into a fixed-point accumulator and subtracts the coefficient fraction. After all terms are in, the integer part of the fraction sum is added into every channel to form the estimate. The integer part of the fraction sum plus the correction count is compared with the plain integer part, and the comparison sets an exactness flag. The estimate is either the true quotient or one less. Software or an outer controller loads both tables through a write port before use.

Top module: `qfs_scaler`

## Requirements
- R1: The base moduli are the K consecutive primes starting at FIRST_PRIME, which must be 2 or 3. Channel j of `q_res` uses the j-th of these primes. The redundant channel `q_me` uses modulus 4 when 2 is in the base and 2 otherwise. Every output residue is strictly below its modulus. With the defaults (K=4, FIRST_PRIME=3) the moduli are 3, 5, 7 and 11, and the redundant modulus is 2.
- R2: A table write occurs on a clock edge with `tbl_we` high. With `tbl_sel`=0 it writes the per-channel table at address i*2^RW + rho. With `tbl_sel`=1 it writes the coefficient table at the address held in the low RCW bits. An entry holds the residue for channel j in bits [j*RW +: RW], the redundant residue in bits [K*RW +: RW] and the fraction in its top WF bits.
- R3: A `start` sampled while idle captures `rho`, `rc` and `corr`, and `busy` is high on the next cycle. A `start` sampled while busy has no effect on the result or its timing.
- R4: `done` is high for exactly one cycle, K+2 clock edges after the edge that accepted `start`. `busy` is low in that cycle, so a `start` in the same cycle is accepted.
- R5: Each base channel output equals (sum over i of the integer residues for rho_i, minus the coefficient integer residue, plus QL) mod m_j.
- R6: The redundant channel output follows the same rule with the redundant modulus.
- R7: The fraction sum Qf is (sum over i of the fractions minus the coefficient fraction) modulo 2^(WI+WF), where WI = ceil(lg K). QL is Qf shifted right by WF.
- R8: `exact` is 1 exactly when QL equals (Qf + corr) shifted right by WF, where the sum is taken without truncation.
- R9: When the tables hold the correct quotient data for divisor D and the true fraction sum is not negative, the estimate equals floor(Z/D) or floor(Z/D) - 1.
- R10: `q_res`, `q_me` and `exact` change only in the cycle in which `done` is high, and they hold their values until the next result.
- R11: After reset, `busy`, `done`, `exact`, `q_res` and `q_me` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an estimate (ignored while busy) |
| rho | input | K*RW | Reconstruction value per channel, channel i at [i*RW +: RW] |
| rc | input | RCW | Reconstruction coefficient |
| corr | input | NW | Correction count added for the exactness test |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | 0 selects the per-channel table, 1 selects the coefficient table |
| tbl_waddr | input | AW | Table write address |
| tbl_wdata | input | EW | Table entry to write |
| busy | output | 1 | Estimate in progress |
| done | output | 1 | One-cycle pulse: results updated |
| q_res | output | K*RW | Quotient estimate residues, channel j at [j*RW +: RW] |
| q_me | output | RW | Quotient estimate residue in the redundant channel |
| exact | output | 1 | Estimate known to be the true quotient |

## Verification
The completion of one estimate and the acceptance of the next can fall in the same cycle. `done` is high, `busy` has just dropped, and a waiting `start` is taken on the following edge. The bench provokes this by raising `start` for a second operand in the very cycle it checks the first operand's results. It then judges the second result by its value and by a latency count of exactly K+2 edges. A related overlap is a `start` raised in the middle of a run. The bench changes every operand input at that moment and requires the first result to come out unchanged and on time.

// File: rtl/qfs_pkg.sv
`timescale 1ns/1ps
package qfs_pkg;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} qfs_state_e;

   function automatic bit is_prime(int v);
      if (v < 2) return 1'b0;
      for (int d = 2; d * d <= v; d++) begin
         if (v % d == 0) return 1'b0;
      end
      return 1'b1;
   endfunction

   // prime number idx (counting from zero) at or above first
   function automatic int prime_at(int first, int idx);
      int c;
      int n;
      c = first;
      n = 0;
      for (int g = 0; g < 4096; g++) begin
         if (is_prime(c)) begin
            if (n == idx) return c;
            n++;
         end
         c++;
      end
      return 0;
   endfunction

   function automatic int spare_mod(int first);
      return (first == 2) ? 4 : 2;
   endfunction

   // modulus of channel j; channel k is the redundant one
   function automatic int chan_mod(int first, int k, int j);
      return (j < k) ? prime_at(first, j) : spare_mod(first);
   endfunction

   function automatic int max_of(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/qfs_ctrl.sv
`timescale 1ns/1ps
module qfs_ctrl
   import qfs_pkg::*;
#(
   parameter int K  = 4,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic          clr,
   output logic          step,
   output logic          last,
   output logic          fin,
   output logic [IW-1:0] idx
);

   qfs_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  st  <= ST_RUN;
                  idx <= '0;
               end
            end
            ST_RUN: begin
               if (idx == IW'(K)) st <= ST_FIN;
               else               idx <= idx + 1'b1;
            end
            ST_FIN: begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign clr  = (st == ST_IDLE) && start;
   assign step = (st == ST_RUN);
   assign last = step && (idx == IW'(K));
   assign fin  = (st == ST_FIN);

endmodule

// File: rtl/qfs_tables.sv
`timescale 1ns/1ps
module qfs_tables #(
   parameter int K   = 4,
   parameter int RW  = 4,
   parameter int EW  = 24,
   parameter int IXW = 2,
   parameter int IW  = 3,
   parameter int RCW = 2,
   parameter int AW  = IXW + RW
) (
   input  logic            clk,
   input  logic            we,
   input  logic            sel,
   input  logic [AW-1:0]   waddr,
   input  logic [EW-1:0]   wdata,
   input  logic            capture,
   input  logic [K*RW-1:0] rho_in,
   input  logic [RCW-1:0]  rc_in,
   input  logic [IW-1:0]   idx,
   input  logic            last,
   output logic [EW-1:0]   entry
);

   localparam int D1 = 2 ** AW;
   localparam int D2 = 2 ** RCW;

   logic [EW-1:0]   t_chan [D1];
   logic [EW-1:0]   t_coef [D2];
   logic [K*RW-1:0] rho_l;
   logic [RCW-1:0]  rc_l;
   logic [RW-1:0]   cur_rho;

   always_ff @(posedge clk) begin
      if (we && !sel) t_chan[waddr] <= wdata;
      if (we && sel)  t_coef[waddr[RCW-1:0]] <= wdata;
      if (capture) begin
         rho_l <= rho_in;
         rc_l  <= rc_in;
      end
   end

   always_comb begin
      cur_rho = '0;
      for (int i = 0; i < K; i++) begin
         if (idx == IW'(i)) cur_rho = rho_l[i*RW +: RW];
      end
      if (last) entry = t_coef[rc_l];
      else      entry = t_chan[{idx[IXW-1:0], cur_rho}];
   end

endmodule

// File: rtl/qfs_chan.sv
`timescale 1ns/1ps
module qfs_chan #(
   parameter int MOD = 3,
   parameter int RW  = 4,
   parameter int QW  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic          sub,
   input  logic          fin,
   input  logic [RW-1:0] term,
   input  logic [QW-1:0] ql,
   output logic [RW-1:0] res
);

   localparam int LW = RW + 1;

   logic [RW-1:0] acc;
   logic [LW-1:0] s_add;
   logic [RW-1:0] nxt_add;
   logic [RW-1:0] nxt_sub;

   always_comb begin
      s_add   = {1'b0, acc} + {1'b0, term};
      nxt_add = (s_add >= LW'(MOD)) ? RW'(s_add - LW'(MOD)) : s_add[RW-1:0];
      if (acc >= term) nxt_sub = acc - term;
      else             nxt_sub = acc + RW'(MOD) - term;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         res <= '0;
      end else begin
         if (clr)       acc <= '0;
         else if (step) acc <= sub ? nxt_sub : nxt_add;
         if (fin) res <= RW'((32'(acc) + 32'(ql)) % 32'(MOD));
      end
   end

endmodule

// File: rtl/qfs_frac.sv
`timescale 1ns/1ps
module qfs_frac #(
   parameter int WF = 4,
   parameter int WT = 6,
   parameter int NW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             sub,
   input  logic             fin,
   input  logic [WF-1:0]    frac_in,
   input  logic [NW-1:0]    corr_in,
   output logic [WT-WF-1:0] ql,
   output logic             exact
);

   logic [WT-1:0] acc;
   logic [NW-1:0] corr_l;
   logic          same;

   assign ql = acc[WT-1:WF];

   always_comb begin
      same = ((({1'b0, acc} + (WT+1)'(corr_l)) >> WF) == (WT+1)'(ql));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         corr_l <= '0;
         exact  <= 1'b0;
      end else begin
         if (clr) begin
            acc    <= '0;
            corr_l <= corr_in;
         end else if (step) begin
            acc <= sub ? acc - WT'(frac_in) : acc + WT'(frac_in);
         end
         if (fin) exact <= same;
      end
   end

endmodule

// File: rtl/qfs_scaler.sv
`timescale 1ns/1ps
module qfs_scaler
   import qfs_pkg::*;
#(
   parameter  int K           = 4,
   parameter  int FIRST_PRIME = 3,
   parameter  int WF          = 4,
   localparam int PMAX = prime_at(FIRST_PRIME, K - 1),
   localparam int ME   = spare_mod(FIRST_PRIME),
   localparam int RW   = $clog2(max_of(PMAX, ME)),
   localparam int IXW  = $clog2(K),
   localparam int RCW  = IXW,
   localparam int AW   = IXW + RW,
   localparam int WI   = $clog2(K),
   localparam int WT   = WI + WF,
   localparam int NW   = $clog2(K + 1),
   localparam int IW   = $clog2(K + 1),
   localparam int EW   = (K + 1) * RW + WF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [K*RW-1:0] rho,
   input  logic [RCW-1:0]  rc,
   input  logic [NW-1:0]   corr,
   input  logic            tbl_we,
   input  logic            tbl_sel,
   input  logic [AW-1:0]   tbl_waddr,
   input  logic [EW-1:0]   tbl_wdata,
   output logic            busy,
   output logic            done,
   output logic [K*RW-1:0] q_res,
   output logic [RW-1:0]   q_me,
   output logic            exact
);

   if (K < 2) begin : g_bad_k
      $error("qfs_scaler: K must be at least 2");
   end
   if (FIRST_PRIME != 2 && FIRST_PRIME != 3) begin : g_bad_first
      $error("qfs_scaler: FIRST_PRIME must be 2 or 3");
   end
   if (WF < $clog2(K + 1)) begin : g_bad_wf
      $error("qfs_scaler: WF must be at least ceil(lg(K+1))");
   end

   logic          clr, step, last, fin;
   logic [IW-1:0] idx;
   logic [EW-1:0] entry;
   logic [WI-1:0] ql;

   qfs_ctrl #(.K(K), .IW(IW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .done(done), .clr(clr), .step(step),
      .last(last), .fin(fin), .idx(idx)
   );

   qfs_tables #(
      .K(K), .RW(RW), .EW(EW), .IXW(IXW), .IW(IW), .RCW(RCW), .AW(AW)
   ) u_tbl (
      .clk(clk), .we(tbl_we), .sel(tbl_sel), .waddr(tbl_waddr),
      .wdata(tbl_wdata), .capture(clr), .rho_in(rho), .rc_in(rc),
      .idx(idx), .last(last), .entry(entry)
   );

   qfs_frac #(.WF(WF), .WT(WT), .NW(NW)) u_frac (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .sub(last),
      .fin(fin), .frac_in(entry[EW-1 -: WF]), .corr_in(corr),
      .ql(ql), .exact(exact)
   );

   for (genvar j = 0; j <= K; j++) begin : g_ch
      localparam int MOD = chan_mod(FIRST_PRIME, K, j);
      logic [RW-1:0] r;

      qfs_chan #(.MOD(MOD), .RW(RW), .QW(WI)) u_ch (
         .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .sub(last),
         .fin(fin), .term(entry[j*RW +: RW]), .ql(ql), .res(r)
      );

      if (j < K) begin : g_base
         assign q_res[j*RW +: RW] = r;
      end else begin : g_spare
         assign q_me = r;
      end
   end

endmodule

// File: rtl/qfs_scaler_chk.sv
`timescale 1ns/1ps
module qfs_scaler_chk
   import qfs_pkg::*;
#(
   parameter int K           = 4,
   parameter int FIRST_PRIME = 3,
   parameter int RW          = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [K*RW-1:0] q_res,
   input logic [RW-1:0]   q_me,
   input logic            exact
);

   int lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lat_cnt <= 0;
      else if (start && !busy) lat_cnt <= 0;
      else if (busy)           lat_cnt <= lat_cnt + 1;
   end

   // R3: an accepted start makes the block busy on the next cycle
   p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R4: done lasts one cycle
   p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: idle while done is shown
   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4 and R3: fixed latency, not restarted by a start while busy
   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == K + 2));

   // R10: results only move with done
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(q_res) && $stable(q_me) && $stable(exact)));

   // R1: residues below their moduli
   for (genvar j = 0; j <= K; j++) begin : g_rng
      localparam int MOD = chan_mod(FIRST_PRIME, K, j);
      if (j < K) begin : g_b
         p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
            32'(q_res[j*RW +: RW]) < MOD);
      end else begin : g_s
         p_range_me_r1: assert property (@(posedge clk) disable iff (!rst_n)
            32'(q_me) < MOD);
      end
   end

endmodule

bind qfs_scaler qfs_scaler_chk #(.K(K), .FIRST_PRIME(FIRST_PRIME), .RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .q_res(q_res), .q_me(q_me), .exact(exact)
);

// File: tb/sim_qfs_scaler.sv
`timescale 1ns/1ps
module sim_qfs_scaler;

   localparam int K    = 4;
   localparam int RW   = 4;
   localparam int WF   = 4;
   localparam int EW   = (K + 1) * RW + WF;
   localparam int SC   = 16;
   localparam int WRAP = 64;
   localparam int BME  = 2;
   localparam int BIGM = 1155;
   localparam int DIV  = 7;
   localparam int BM[4] = '{3, 5, 7, 11};

   // Z, corr, floor(Z/7)
   localparam int VEC[10][3] = '{
      '{0, 0, 0}, '{1, 1, 0}, '{6, 3, 0}, '{7, 7, 1}, '{100, 2, 14},
      '{343, 5, 49}, '{500, 0, 71}, '{777, 4, 111}, '{1000, 6, 142},
      '{1154, 1, 164}};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [K*RW-1:0] rho_in = '0;
   logic [1:0]      rc_in = '0;
   logic [2:0]      corr_in = '0;
   logic            tbl_we = 1'b0;
   logic            tbl_sel = 1'b0;
   logic [5:0]      tbl_waddr = '0;
   logic [EW-1:0]   tbl_wdata = '0;
   logic            busy, done, exact;
   logic [K*RW-1:0] q_res;
   logic [RW-1:0]   q_me;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   qfs_scaler u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .rho(rho_in), .rc(rc_in),
      .corr(corr_in), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
      .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .busy(busy),
      .done(done), .q_res(q_res), .q_me(q_me), .exact(exact)
   );

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int modp(int x, int m);
      int r;
      r = x % m;
      return (r < 0) ? r + m : r;
   endfunction

   function automatic int inv_of(int a, int m);
      for (int t = 1; t < m; t++) if ((a * t) % m == 1) return t;
      return 0;
   endfunction

   // R2: entry layout
   function automatic logic [EW-1:0] pack(int q, int f);
      logic [EW-1:0] d;
      d = '0;
      for (int j = 0; j < K; j++) d[j*RW +: RW] = RW'(modp(q, BM[j]));
      d[K*RW +: RW] = RW'(modp(q, BME));
      d[EW-1 -: WF] = WF'(f);
      return d;
   endfunction

   task automatic put(bit sel, int addr, logic [EW-1:0] d);
      tbl_we    = 1'b1;
      tbl_sel   = sel;
      tbl_waddr = 6'(addr);
      tbl_wdata = d;
      @(negedge clk);
      tbl_we    = 1'b0;
   endtask

   task automatic load_tables();
      for (int i = 0; i < K; i++) begin
         for (int r = 0; r < BM[i]; r++) begin
            int v;
            v = (BIGM / BM[i]) * r;
            put(1'b0, i * 16 + r, pack(v / DIV, ((v % DIV) * SC) / DIV));
         end
      end
      for (int c = 0; c < K; c++) begin
         int v;
         v = c * BIGM;
         put(1'b1, c, pack(v / DIV, ((v % DIV) * SC + DIV - 1) / DIV));
      end
   endtask

   // runs one estimate; call at a negedge
   task automatic go(int z, int n, int qtrue, bit disturb);
      int rho[4];
      int s, qint, qf, qfw, ql, qh, est, rc, cyc;
      s = 0; qint = 0; qf = 0;
      for (int i = 0; i < K; i++) begin
         int mi, v;
         mi = BIGM / BM[i];
         rho[i] = ((z % BM[i]) * inv_of(mi % BM[i], BM[i])) % BM[i];
         s += rho[i] * mi;
         v = mi * rho[i];
         qint += v / DIV;
         qf += ((v % DIV) * SC) / DIV;
      end
      rc = (s - z) / BIGM;
      qint -= (rc * BIGM) / DIV;
      qf -= (((rc * BIGM) % DIV) * SC + DIV - 1) / DIV;
      qfw = modp(qf, WRAP);
      ql = qfw / SC;
      qh = (qfw + n) / SC;
      est = qint + ql;
      for (int i = 0; i < K; i++) rho_in[i*RW +: RW] = RW'(rho[i]);
      rc_in = 2'(rc);
      corr_in = 3'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 200) begin
         if (disturb && cyc == 2) begin
            start   = 1'b1;
            rho_in  = ~rho_in;
            corr_in = ~corr_in;
            rc_in   = rc_in + 2'd1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(disturb ? "R3 latency with start while busy" : "R4 latency", cyc, K + 3);
      check("R4 busy low with done", int'(busy), 0);
      for (int j = 0; j < K; j++) begin
         check("R2/R5/R7 channel residue", int'(q_res[j*RW +: RW]), modp(est, BM[j]));
         check("R1 residue in range", int'(int'(q_res[j*RW +: RW]) < BM[j]), 1);
      end
      check("R6 redundant residue", int'(q_me), modp(est, BME));
      check("R8 exact flag", int'(exact), int'(ql == qh));
      if (qf >= 0)
         check("R9 estimate within one", int'(est == qtrue || est == qtrue - 1), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [K*RW-1:0] s_res;
      logic [RW-1:0]   s_me;
      logic            s_ex;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11
      check("R11 busy after reset", int'(busy), 0);
      check("R11 done after reset", int'(done), 0);
      check("R11 exact after reset", int'(exact), 0);
      check("R11 q_res after reset", int'(q_res), 0);
      check("R11 q_me after reset", int'(q_me), 0);
      load_tables();

      for (int v = 0; v < 10; v++) begin
         go(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0);
         @(negedge clk);
      end

      // R4: next start raised in the done cycle
      go(500, 3, 71, 1'b0);
      check("R4 done seen before back-to-back start", int'(done), 1);
      go(1000, 0, 142, 1'b0);

      // R10: results held
      s_res = q_res;
      s_me  = q_me;
      s_ex  = exact;
      repeat (3) begin
         @(negedge clk);
         check("R10 q_res held", int'(q_res), int'(s_res));
         check("R10 q_me held", int'(q_me), int'(s_me));
         check("R10 exact held", int'(exact), int'(s_ex));
         check("R10 no done", int'(done), 0);
      end

      // R3: start while busy with altered operands
      go(777, 2, 111, 1'b1);
      @(negedge clk);
      check("R3 busy after ignored start", int'(busy), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule